// File: doc/BRIEF.md
# ECC Error Capture and Status Logger

This block sits beside the ECC check logic of a DRAM datapath and keeps a record of the memory errors it reports. Each cycle the datapath may flag a correctable error (CE), an uncorrectable error (UE), or both. Each flag comes with the physical address of the failing access, its 8-bit syndrome and the channel it used. The logger keeps one sticky status bit per error class. It also holds a single captured record made of the 4 KiB address page, the syndrome and the channel.

A UE always takes priority. It replaces the record of a CE that is already logged, but it does not replace the record of an earlier UE. A CE only fills the record when nothing is logged. Software reads the record through a small register port and clears the status bits by writing 1 to them. A command register selects which error classes drive a level-sensitive system-error output.

Register selects (`reg_sel`):
- 0: status. Bit 0 is CE and bit 7 is UE. The bits are write-1-to-clear.
- 1: command. Bit 8 enables the output for UE and bit 7 enables it for CE.
- 2: captured address.
- 3: syndrome.
- 4: channel.

Any other select reads zero. Reads are combinational. A write takes effect at the clock edge.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, every register reads zero and `serr` is low.
- R2: A CE event sets status bit 0 and a UE event sets status bit 7 at the next clock edge. The other status bits always read zero.
- R3: A write to select 0 clears status bit 0 when `reg_wdata[0]` is 1 and clears status bit 7 when `reg_wdata[7]` is 1. A 0 in either position leaves that bit unchanged, so the value 0x0081 clears both.
- R4: An event that arrives while nothing is logged captures its record, read back as follows:
  - select 2 returns `evt_addr[31:12]` in bits 31:12 and zero in bits 11:0;
  - select 3 returns the syndrome in bits 7:0;
  - select 4 returns the channel in bit 0 and zero in bits 7:1.
- R5: A UE that arrives while only a CE is logged overwrites the captured address, syndrome and channel with its own.
- R6: A CE that arrives while a CE or a UE is logged leaves the captured record unchanged.
- R7: A UE that arrives while a UE is logged leaves the captured record unchanged.
- R8: When a clear write and a new event occur in the same cycle, the event wins. Its status bit stays set, and its record is captured as if the cleared bit had not been logged.
- R9: Command bits 8 and 7 are writable through select 1. All other command bits read zero.
- R10: `serr` is high exactly when (status bit 7 AND command bit 8) OR (status bit 0 AND command bit 7) is true.
- R11: When a CE and a UE arrive in the same cycle with nothing logged, both status bits are set and the record holds the event's address, syndrome and channel under UE priority.
- R12: Writes to selects 2 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_valid | input | 1 | Correctable error event this cycle |
| ue_valid | input | 1 | Uncorrectable error event this cycle |
| evt_addr | input | 32 | Physical address of the failing access |
| evt_syn | input | 8 | ECC syndrome of the failing access |
| evt_chan | input | 1 | Channel of the failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| serr | output | 1 | System-error level |

## Verification
Directed sequences exercise each ordering that decides the record:
- a CE followed by a CE, then by a UE, which shows whether UE priority replaces a CE record;
- a UE followed by a UE, which shows whether the first UE is kept;
- a CE after a UE;
- a CE and a UE in the same cycle.

Clear writes that coincide with events tell an event-wins design from a clear-wins design. Writes of 0 to the status bits and writes to read-only selects show that those writes have no effect.

Random traffic then mixes events with writes to every select. After every cycle, each register and `serr` are compared with a bench model, which exposes errors in the command-enable masking and in the mask of writable bits.

// File: rtl/ecc_err_logger.sv
module ecc_err_logger #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SYN_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_valid,
  input  logic              ue_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic              evt_chan,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              serr
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  logic              st_ce, st_ue, en_ce, en_ue, rec_chan;
  logic [PAGE_W-1:0] rec_page;
  logic [SYN_W-1:0]  rec_syn;

  wire wr_status = reg_wr && (reg_sel == 3'd0);
  wire wr_cmd    = reg_wr && (reg_sel == 3'd1);
  wire kept_ce   = st_ce && !(wr_status && reg_wdata[0]);
  wire kept_ue   = st_ue && !(wr_status && reg_wdata[7]);
  wire take_ue   = ue_valid && !kept_ue;
  wire take_ce   = ce_valid && !ue_valid && !kept_ce && !kept_ue;
  wire unused_ok = ^{reg_wdata, evt_addr[PAGE_SHIFT-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ce    <= 1'b0;
      st_ue    <= 1'b0;
      en_ce    <= 1'b0;
      en_ue    <= 1'b0;
      rec_page <= '0;
      rec_syn  <= '0;
      rec_chan <= 1'b0;
    end else begin
      st_ce <= kept_ce || ce_valid;
      st_ue <= kept_ue || ue_valid;
      if (wr_cmd) begin
        en_ce <= reg_wdata[7];
        en_ue <= reg_wdata[8];
      end
      if (take_ue || take_ce) begin
        rec_page <= evt_addr[ADDR_W-1:PAGE_SHIFT];
        rec_syn  <= evt_syn;
        rec_chan <= evt_chan;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      3'd0: begin reg_rdata[0] = st_ce; reg_rdata[7] = st_ue; end
      3'd1: begin reg_rdata[7] = en_ce; reg_rdata[8] = en_ue; end
      3'd2: reg_rdata[ADDR_W-1:PAGE_SHIFT] = rec_page;
      3'd3: reg_rdata[SYN_W-1:0] = rec_syn;
      3'd4: reg_rdata[0] = rec_chan;
      default: reg_rdata = '0;
    endcase
  end

  assign serr = (st_ue && en_ue) || (st_ce && en_ce);
endmodule

module ecc_err_logger_chk #(
  parameter int PAGE_W = 20,
  parameter int SYN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_valid,
  input logic              ue_valid,
  input logic [PAGE_W-1:0] evt_page,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic              wbit7,
  input logic              st_ce,
  input logic              st_ue,
  input logic              serr,
  input logic [PAGE_W-1:0] rec_page,
  input logic [SYN_W-1:0]  rec_syn
);
  AST_CE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ce_valid |=> st_ce); // R2
  AST_UE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ue_valid |=> st_ue); // R2
  AST_UE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd0 && wbit7 && !ue_valid) |=> !st_ue); // R3
  AST_UE_OVER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ce && !st_ue && ue_valid) |=> rec_page == $past(evt_page)); // R5
  AST_CE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_ce || st_ue) && ce_valid && !ue_valid && !reg_wr) |=> $stable(rec_syn)); // R6
  AST_UE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ue && ue_valid && !reg_wr) |=> $stable(rec_page)); // R7
  AST_SERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_ce && !st_ue) |-> !serr); // R10
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.PAGE_W(PAGE_W), .SYN_W(SYN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_valid(ce_valid), .ue_valid(ue_valid),
  .evt_page(evt_addr[ADDR_W-1:PAGE_SHIFT]), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .wbit7(reg_wdata[7]), .st_ce(st_ce), .st_ue(st_ue), .serr(serr),
  .rec_page(rec_page), .rec_syn(rec_syn)
);

// File: tb/tb_ecc_err_logger.sv
`timescale 1ns/1ps
module tb_ecc_err_logger;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ce_valid = 0, ue_valid = 0, evt_chan = 0, reg_wr = 0;
  logic [31:0] evt_addr = 0, reg_wdata = 0;
  logic [7:0]  evt_syn = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_rdata;
  logic        serr;
  int          n_chk = 0, n_bad = 0;

  logic        m_ce, m_ue, m_ence, m_enue, m_chan;
  logic [19:0] m_page;
  logic [7:0]  m_syn;

  ecc_err_logger dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_reg(input logic [2:0] s);
    case (s)
      3'd0: return {24'd0, m_ue, 6'd0, m_ce};
      3'd1: return {23'd0, m_enue, m_ence, 7'd0};
      3'd2: return {m_page, 12'd0};
      3'd3: return {24'd0, m_syn};
      3'd4: return {31'd0, m_chan};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic model_serr();
    return (m_ue & m_enue) | (m_ce & m_ence);
  endfunction

  task automatic model_reset();
    m_ce = 0; m_ue = 0; m_ence = 0; m_enue = 0; m_chan = 0; m_page = 0; m_syn = 0;
  endtask

  task automatic cyc(input logic ce, input logic ue, input logic [31:0] a, input logic [7:0] sy,
                     input logic ch, input logic wr, input logic [2:0] s, input logic [31:0] wd);
    logic kce, kue;
    @(negedge clk);
    ce_valid = ce; ue_valid = ue; evt_addr = a; evt_syn = sy; evt_chan = ch;
    reg_wr = wr; reg_sel = s; reg_wdata = wd;
    @(posedge clk);
    kce = m_ce & ~(wr && s == 0 && wd[0]);
    kue = m_ue & ~(wr && s == 0 && wd[7]);
    if ((ue && !kue) || (ce && !ue && !kce && !kue)) begin
      m_page = a[31:12]; m_syn = sy; m_chan = ch;
    end
    m_ce = kce | ce; m_ue = kue | ue;
    if (wr && s == 1) begin m_ence = wd[7]; m_enue = wd[8]; end
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] exp, input string tag);
    @(negedge clk);
    ce_valid = 0; ue_valid = 0; reg_wr = 0; reg_sel = s;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic rec(input logic [31:0] a, input logic [7:0] sy, input logic [31:0] ch, input string tag);
    rd(2, a, tag); rd(3, {24'd0, sy}, tag); rd(4, ch, tag);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int s = 0; s < 5; s++) rd(s[2:0], 0, "R1 reset reg");
    #1 chk("R1 reset serr", {31'd0, serr}, 0);

    cyc(1, 0, 32'h1234_5ABC, 8'h5A, 1, 0, 0, 0);
    rd(0, 32'h0001, "R2 CE status");
    rec(32'h1234_5000, 8'h5A, 1, "R4 CE capture");
    cyc(1, 0, 32'hAAAA_AFFF, 8'h11, 0, 0, 0, 0);
    rec(32'h1234_5000, 8'h5A, 1, "R6 CE over CE");
    cyc(0, 1, 32'h8765_4321, 8'hC3, 0, 0, 0, 0);
    rd(0, 32'h0081, "R2 UE status");
    rec(32'h8765_4000, 8'hC3, 0, "R5 UE over CE");
    cyc(0, 1, 32'h0000_3FFF, 8'h77, 1, 0, 0, 0);
    rec(32'h8765_4000, 8'hC3, 0, "R7 UE over UE");
    cyc(1, 0, 32'hFFFF_F000, 8'h99, 1, 0, 0, 0);
    rec(32'h8765_4000, 8'hC3, 0, "R6 CE over UE");
    cyc(0, 0, 0, 0, 0, 1, 2, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 0, 0, 1, 3, 32'hFFFF_FFFF);
    cyc(0, 0, 0, 0, 0, 1, 4, 32'hFFFF_FFFF);
    rec(32'h8765_4000, 8'hC3, 0, "R12 read-only writes");

    cyc(0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF);
    rd(1, 32'h0180, "R9 cmd mask");
    #1 chk("R10 serr both", {31'd0, serr}, 1);
    cyc(0, 0, 0, 0, 0, 1, 1, 32'h0000_0080);
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_0000);
    rd(0, 32'h0081, "R3 write zero keeps");
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_0001);
    rd(0, 32'h0080, "R3 clear CE");
    #1 chk("R10 serr UE not enabled", {31'd0, serr}, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_0080);
    rd(0, 32'h0000, "R3 clear UE");

    cyc(1, 0, 32'h0101_0000, 8'h0F, 0, 0, 0, 0);
    #3 chk("R10 serr CE enabled", {31'd0, serr}, 1);
    cyc(1, 0, 32'h0202_0000, 8'hF0, 1, 1, 0, 32'h0000_0081);
    rd(0, 32'h0001, "R8 event wins status");
    rec(32'h0202_0000, 8'hF0, 1, "R8 event wins record");
    cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_0081);
    cyc(1, 1, 32'h0303_0ABC, 8'hE1, 1, 0, 0, 0);
    rd(0, 32'h0081, "R11 both status");
    rec(32'h0303_0000, 8'hE1, 1, "R11 both record");

    void'($urandom(32'd1357));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      cyc(r[1:0] == 0, r[4:2] == 0, $urandom, r[15:8], r[16], r[19:18] == 0,
          r[22:20], $urandom);
      for (int s = 0; s < 8; s++) rd(s[2:0], model_reg(s[2:0]), "R2 R4 random reg");
      #1 chk("R10 random serr", {31'd0, serr}, {31'd0, model_serr()});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule